// File: doc/BRIEF.md
# Supply-Monitor Power-Up Recall Sequencer

This block sits between a set of external supply comparators and the controller of a memory whose static array is shadowed by a nonvolatile copy. It receives three active-high level flags from the comparators:

- a brownout flag, high when the supply has dropped below the low-power threshold;
- a sense flag, high when the supply is above the sense threshold;
- an inhibit flag, high when the supply is below the store-inhibit threshold.

Each flag is first re-timed through a two-stage synchronizer. The block then decides when the array must be reloaded from its nonvolatile copy.

A recall request is held pending from reset and after every brownout. The automatic recall is launched only once the supply is back above the sense threshold. While the recall runs, the block holds off normal accesses for a fixed number of clock cycles. Store requests from the mode controller are masked whenever the supply is too low to program safely, and also while a recall is running. If the access strobes show a write condition at the moment the recall finishes, the array contents cannot be trusted, so the block raises a one-cycle error.

Top module: `pwr_recall_seq`

## Requirements
- R1: Each of the three supply flags passes through two flip-flop stages before use. A flag change that is set up before clock edge k can first affect a registered output after edge k+2. Out of reset the stages hold brownout=1, sense=0, inhibit=1.
- R2: A pending-recall latch is set by reset and in every cycle the synchronized brownout flag is 1. It is cleared only when an automatic recall starts.
- R3: When no recall is running, the latch is set, the synchronized sense flag is 1 and the synchronized brownout flag is 0, `recall_start_o` pulses for exactly one cycle.
- R4: `busy_o` rises in the same cycle as the start pulse and stays high for exactly RESTORE_CYC cycles.
- R5: A brownout seen while a recall is running does not cut it short. It re-arms the latch, so a further recall starts once the first one ends and the supply is above sense.
- R6: `ready_o` is 0 from reset until the first automatic recall completes. After that it is 1 whenever `busy_o` is 0, and it is always 0 while `busy_o` is 1.
- R7: `store_inhibit_o` is 1 when the synchronized inhibit flag is 1 or a recall is running. `store_go_o` equals `store_req_i` masked by `store_inhibit_o`.
- R8: If `wr_cond_i` is 1 in the last busy cycle of a recall, `wr_err_o` is 1 for the single cycle that follows. Otherwise it stays 0.
- R9: A rising sense flag with no pending request starts no recall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_brownout_i | input | 1 | Raw flag: supply below low-power threshold |
| sup_above_sense_i | input | 1 | Raw flag: supply above sense threshold |
| sup_below_inhib_i | input | 1 | Raw flag: supply below store-inhibit threshold |
| store_req_i | input | 1 | Store request from the mode controller |
| wr_cond_i | input | 1 | Access strobes currently form a write condition |
| recall_start_o | output | 1 | One-cycle automatic recall start pulse |
| store_inhibit_o | output | 1 | Stores must not run |
| store_go_o | output | 1 | Store request passed through the inhibit mask |
| ready_o | output | 1 | Array may be accessed normally |
| busy_o | output | 1 | Automatic recall in progress |
| wr_err_o | output | 1 | Write condition seen as a recall finished |

## Verification
Two events are deliberately made to coincide with the end of a recall: a write condition held on the strobes through the final busy cycle, and a brownout pulse that arrives while the timer runs out. The first must give an error pulse in the same cycle that `ready_o` rises. The second must leave the latch armed, so that a new start pulse follows after a single idle cycle. Both are provoked in a directed sequence and again by sparse random flag toggling. A behavioural model with queue-based synchronizers predicts every output on every cycle, and the outputs are compared against it.

// File: rtl/prs_pkg.sv
package prs_pkg;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RECALL = 1'b1
    } prs_state_e;

    typedef struct packed {
        prs_state_e state;
        logic       pending;
        logic       done_once;
        logic       start;
        logic       wr_err;
    } prs_regs_t;

    localparam int unsigned FLAG_BROWN = 0;
    localparam int unsigned FLAG_ABOVE = 1;
    localparam int unsigned FLAG_INHIB = 2;
    localparam int unsigned NUM_FLAGS  = 3;

    // reset view of the supply: browned out, below sense, stores inhibited
    localparam logic [NUM_FLAGS-1:0] FLAG_RST = 3'b101;

endpackage

// File: rtl/prs_sync.sv
module prs_sync #(
    parameter int unsigned           W       = 3,
    parameter int unsigned           STAGES  = 2,
    parameter logic [W-1:0]          RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/prs_restore_timer.sv
module prs_restore_timer #(
    parameter int unsigned CYCLES = 55000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    output logic last_o
);

    localparam int unsigned     CW       = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0]   LOAD_VAL = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = LOAD_VAL;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last_o = (cnt_q == '0);

endmodule

// File: rtl/pwr_recall_seq.sv
module pwr_recall_seq
    import prs_pkg::*;
#(
    parameter int unsigned RESTORE_CYC = 55000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_brownout_i,
    input  logic sup_above_sense_i,
    input  logic sup_below_inhib_i,
    input  logic store_req_i,
    input  logic wr_cond_i,
    output logic recall_start_o,
    output logic store_inhibit_o,
    output logic store_go_o,
    output logic ready_o,
    output logic busy_o,
    output logic wr_err_o
);

    logic [NUM_FLAGS-1:0] raw_flags;
    logic [NUM_FLAGS-1:0] syn_flags;
    logic                 brown_s, above_s, inhib_s;
    logic                 tmr_load, tmr_last, in_recall;
    prs_regs_t            r_d, r_q;

    assign raw_flags[FLAG_BROWN] = sup_brownout_i;
    assign raw_flags[FLAG_ABOVE] = sup_above_sense_i;
    assign raw_flags[FLAG_INHIB] = sup_below_inhib_i;

    prs_sync #(
        .W       (NUM_FLAGS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (FLAG_RST)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_flags),
        .sync_o  (syn_flags)
    );

    assign brown_s = syn_flags[FLAG_BROWN];
    assign above_s = syn_flags[FLAG_ABOVE];
    assign inhib_s = syn_flags[FLAG_INHIB];

    assign in_recall = (r_q.state == ST_RECALL);

    prs_restore_timer #(
        .CYCLES (RESTORE_CYC)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .run_i  (in_recall),
        .last_o (tmr_last)
    );

    always_comb begin
        r_d        = r_q;
        r_d.start  = 1'b0;
        r_d.wr_err = 1'b0;
        tmr_load   = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (r_q.pending && above_s && !brown_s) begin
                    r_d.state   = ST_RECALL;
                    r_d.pending = 1'b0;
                    r_d.start   = 1'b1;
                    tmr_load    = 1'b1;
                end
            end
            ST_RECALL: begin
                if (tmr_last) begin
                    r_d.state     = ST_IDLE;
                    r_d.done_once = 1'b1;
                    r_d.wr_err    = wr_cond_i;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
        if (brown_s) begin
            r_d.pending = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state     <= ST_IDLE;
            r_q.pending   <= 1'b1;
            r_q.done_once <= 1'b0;
            r_q.start     <= 1'b0;
            r_q.wr_err    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign recall_start_o  = r_q.start;
    assign busy_o          = in_recall;
    assign ready_o         = r_q.done_once & ~in_recall;
    assign store_inhibit_o = inhib_s | in_recall;
    assign store_go_o      = store_req_i & ~store_inhibit_o;
    assign wr_err_o        = r_q.wr_err;

endmodule

// File: rtl/prs_checker.sv
module prs_checker #(
    parameter int unsigned RESTORE_CYC = 55000
) (
    input logic clk,
    input logic rst_n,
    input logic store_req_i,
    input logic recall_start_o,
    input logic store_inhibit_o,
    input logic store_go_o,
    input logic ready_o,
    input logic busy_o,
    input logic wr_err_o
);

    int unsigned run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= 0;
        end else if (busy_o) begin
            run_len <= recall_start_o ? 1 : run_len + 1;
        end else begin
            run_len <= 0;
        end
    end

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        recall_start_o |=> !recall_start_o);  // R3
    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        recall_start_o |-> !$past(busy_o));  // R3
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        recall_start_o |-> busy_o);  // R4
    AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (run_len == RESTORE_CYC));  // R4
    AST_NOT_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !ready_o);  // R6
    AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> (ready_o || busy_o));  // R6
    AST_STORE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        store_inhibit_o |-> !store_go_o);  // R7
    AST_STORE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req_i && !store_inhibit_o) |-> store_go_o);  // R7
    AST_ERR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err_o |-> ($past(busy_o) && !busy_o));  // R8

endmodule

bind pwr_recall_seq prs_checker #(
    .RESTORE_CYC (RESTORE_CYC)
) u_prs_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .store_req_i     (store_req_i),
    .recall_start_o  (recall_start_o),
    .store_inhibit_o (store_inhibit_o),
    .store_go_o      (store_go_o),
    .ready_o         (ready_o),
    .busy_o          (busy_o),
    .wr_err_o        (wr_err_o)
);

// File: tb/tb_pwr_recall_seq.sv
`timescale 1ns/1ps
module tb_pwr_recall_seq;

    localparam int unsigned N = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic brown = 1'b1, above = 1'b0, inhib = 1'b1, sreq = 1'b0, wr = 1'b0;
    logic start_o, inh_o, go_o, rdy_o, busy_o, err_o;

    int checks = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pwr_recall_seq #(.RESTORE_CYC(N)) dut (
        .clk(clk), .rst_n(rst_n),
        .sup_brownout_i(brown), .sup_above_sense_i(above), .sup_below_inhib_i(inhib),
        .store_req_i(sreq), .wr_cond_i(wr),
        .recall_start_o(start_o), .store_inhibit_o(inh_o), .store_go_o(go_o),
        .ready_o(rdy_o), .busy_o(busy_o), .wr_err_o(err_o)
    );

    // behavioural reference model
    bit qb[$], qa[$], qi[$];
    bit m_pend, m_busy, m_done, m_start, m_err;
    int m_left;

    task automatic model_reset();
        qb = '{1'b1, 1'b1}; qa = '{1'b0, 1'b0}; qi = '{1'b1, 1'b1};
        m_pend = 1; m_busy = 0; m_done = 0; m_start = 0; m_err = 0; m_left = 0;
    endtask

    initial model_reset();

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            bit b2, a2;
            b2 = qb[0]; a2 = qa[0];
            m_start = 0; m_err = 0;
            if (!m_busy && m_pend && a2 && !b2) begin
                m_start = 1; m_busy = 1; m_left = N - 1; m_pend = 0;
            end else if (m_busy) begin
                if (m_left == 0) begin
                    m_busy = 0; m_done = 1; m_err = wr;
                end else begin
                    m_left--;
                end
            end
            if (b2) m_pend = 1;
            qb.push_back(brown); void'(qb.pop_front());
            qa.push_back(above); void'(qa.pop_front());
            qi.push_back(inhib); void'(qi.pop_front());
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the clock edge
    always @(posedge clk) begin
        #3;
        chk("R3 recall_start", start_o, m_start);
        chk("R4 busy", busy_o, m_busy);
        chk("R6 ready", rdy_o, m_done & ~m_busy);
        chk("R7 store_inhibit", inh_o, qi[0] | m_busy);
        chk("R7 store_go", go_o, sreq & ~(qi[0] | m_busy));
        chk("R8 wr_err", err_o, m_err);
    end

    task automatic at_sample(input int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int starts;
        bit seen_b2b;
        at_sample(2);
        // R1 R6: reset state
        chk("R6 ready in reset", rdy_o, 1'b0);
        chk("R4 busy in reset", busy_o, 1'b0);
        chk("R1 inhibit stage reset", inh_o, 1'b1);
        @(negedge clk); rst_n = 1'b1;
        at_sample(4);
        chk("R2 no start below sense", start_o, 1'b0);

        // power restored: brownout clears, sense high, inhibit off
        @(negedge clk); brown = 0; above = 1; inhib = 0; wr = 1;
        at_sample(2);
        chk("R1 start not before third edge", start_o, 1'b0);
        at_sample(1);
        chk("R1 R3 start on third edge", start_o, 1'b1);
        chk("R4 busy with start", busy_o, 1'b1);
        chk("R6 not ready during recall", rdy_o, 1'b0);
        at_sample(N - 1);
        chk("R4 busy last cycle", busy_o, 1'b1);
        at_sample(1);
        chk("R4 busy ends after N", busy_o, 1'b0);
        chk("R6 ready after first recall", rdy_o, 1'b1);
        chk("R8 error for write at end", err_o, 1'b1);
        @(negedge clk); wr = 0; sreq = 1;
        #1 chk("R7 store passes", go_o, 1'b1);
        @(negedge clk); inhib = 1;
        at_sample(2);
        chk("R7 store masked below inhibit", go_o, 1'b0);
        @(negedge clk); sreq = 0; inhib = 0;

        // R9: sense toggles without a pending request
        @(negedge clk); above = 0;
        repeat (4) @(negedge clk);
        above = 1;
        starts = 0;
        repeat (8) begin at_sample(1); if (start_o) starts++; end
        chk("R9 no recall without pending", starts != 0, 1'b0);

        // R2 R5: brownout, then re-arm during the recall
        @(negedge clk); brown = 1; above = 0;
        repeat (3) @(negedge clk);
        brown = 0; above = 1;
        while (!start_o) at_sample(1);
        repeat (N - 4) @(negedge clk);
        brown = 1; wr = 1;
        repeat (4) @(negedge clk);
        brown = 0; wr = 0;
        seen_b2b = 0;
        repeat (N + 8) begin at_sample(1); if (start_o) seen_b2b = 1; end
        chk("R5 re-armed recall follows", seen_b2b, 1'b1);

        // random phase with sparse supply changes
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            if ($urandom_range(0, 29) == 0) brown = ~brown;
            if ($urandom_range(0, 24) == 0) above = ~above;
            if ($urandom_range(0, 39) == 0) inhib = ~inhib;
            sreq = 1'($urandom_range(0, 1));
            wr   = 1'($urandom_range(0, 3) == 0);
        end
        at_sample(2);
        summary();
    end

endmodule